// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Controller with Row Refresh Sweeper

This block connects a single-request host port to a dynamic memory of 2048 rows by 2048 columns with 4 bits per location, 16 Mbit in all. The host presents a 22-bit word address. The controller sends the upper 11 bits as the row, with the row strobe, and then the lower 11 bits as the column, with the column strobe, over one shared 11-bit address bus. Every strobe and data output is active low where it is a strobe, and all of them come from registers.

A read empties the addressed cell. The controller captures the value, returns it to the host, and writes it back into the same column before it closes the row. A write places the data on the memory data lines one cycle before it asserts the column strobe and the write enable.

A refresh sequencer sweeps all 2048 rows in ascending order, opening and closing each row without a column strobe so that the memory restores the row internally. One sweep runs immediately after reset. After that, a sweep starts each time an idle-interval counter expires. A pending sweep takes precedence over a new host request, but it waits for an access that has already started. Host requests are held off while a sweep runs.

Top module: `dram_ctrl`

## Requirements
- R1: After reset, all three strobes are high (inactive), the handshake and result outputs are low, and `req_ready` stays low until a refresh of all 2048 rows has completed.
- R2: A refresh sweep opens rows 0, 1, ..., 2047 in ascending order. Each row is opened with `mem_ras_n` low and its number on `mem_addr`, and is closed again with `mem_cas_n` and `mem_we_n` held high throughout.
- R3: A host access first drives row `req_addr[21:11]` on `mem_addr` with `mem_ras_n` low for at least one cycle. Only after that is `mem_cas_n` lowered.
- R4: The column strobe cycle of a host access carries column `req_addr[10:0]` on `mem_addr`.
- R5: A write presents `req_wdata` on `mem_wdata` in the cycle before the cycle in which `mem_cas_n` and `mem_we_n` are both low, and keeps it unchanged through that cycle. `wr_ack` pulses for one cycle, 3 cycles after the accepting clock edge.
- R6: A read returns the stored value on `rd_data`, qualified by a one-cycle `rd_valid` pulse 6 cycles after the accepting edge. Before the row strobe rises, the controller writes the same value back into the same location, so a second read of that location returns it again.
- R7: When the idle interval expires, the next sweep begins. With the host idle, the row strobe falls `REF_INTERVAL`+1 cycles after the row strobe of row 2047 rose. `req_ready` is low from the moment a sweep is pending until row 2047 has been refreshed, and no request is accepted during a sweep.
- R8: Only one request is outstanding at a time: `req_ready` is low from the accepting edge until the `rd_valid` or `wr_ack` pulse.
- R9: A sweep never interrupts a host access. No refresh row cycle begins while a request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on a clock edge where both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in [21:11], column in [10:0] |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle read completion pulse |
| rd_data | output | 4 | Read data, valid with `rd_valid` |
| wr_ack | output | 1 | One-cycle write completion pulse |
| mem_addr | output | 11 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low, valid with column strobe |
| mem_wdata | output | 4 | Data driven to the memory |
| mem_rdata | input | 4 | Data returned by the memory after a read column strobe |

## Verification
Two situations are hard to reach from the ports.

The first is a missing write-back after a read, because a non-destructive memory would hide it. The bench's memory model therefore clears a cell when it is read, and flags any row that closes while a drained cell is still pending. Repeated reads of the same address then expose any lost data.

The second is a collision between refresh and traffic: a pending sweep meeting a new request, and an expiry that lands in the middle of an access. To reach it, the bench shortens the refresh interval and issues a long stream of back-to-back accesses to generated addresses, so that sweeps fall due at many different phases of an access. It also leaves one interval completely idle, so the exact gap before the next sweep can be measured.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_A_ROW,
    ST_A_COL,
    ST_A_CAPT,
    ST_A_PREP,
    ST_A_REST,
    ST_A_DONE,
    ST_R_OPEN,
    ST_R_HOLD,
    ST_R_CLOSE
  } ctrl_state_t;
endpackage

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int ROW_BITS = 11,
  parameter int INTERVAL = 15000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                step,
  output logic                pending,
  output logic                busy,
  output logic [ROW_BITS-1:0] row
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b1;
      busy     <= 1'b0;
      row      <= '0;
      idle_cnt <= '0;
    end else if (start) begin
      pending  <= 1'b0;
      busy     <= 1'b1;
      row      <= '0;
      idle_cnt <= '0;
    end else if (busy) begin
      if (step) begin
        row <= row + 1'b1;
        if (row == {ROW_BITS{1'b1}}) busy <= 1'b0;
      end
    end else if (!pending) begin
      if (idle_cnt == CW'(INTERVAL - 1)) pending <= 1'b1;
      else idle_cnt <= idle_cnt + 1'b1;
    end
  end

  // R2
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (row == $past(row) + 1'b1));

  // R7
  no_pending_in_sweep_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !pending);
endmodule

// File: rtl/dram_access_fsm.sv
module dram_access_fsm
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_BITS = 11,
  parameter int COL_BITS = 11,
  parameter int DATA_W   = 4,
  localparam int ADDR_W  = ROW_BITS + COL_BITS,
  localparam int BUS_W   = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                wr_ack,
  output logic [BUS_W-1:0]    mem_addr,
  output logic                mem_ras_n,
  output logic                mem_cas_n,
  output logic                mem_we_n,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                ref_pending,
  input  logic                ref_busy,
  input  logic [ROW_BITS-1:0] ref_row,
  output logic                ref_start,
  output logic                ref_step
);
  ctrl_state_t         state;
  logic [COL_BITS-1:0] col_q;
  logic                wr_q;

  assign req_ready = (state == ST_IDLE) && !ref_pending;
  assign ref_start = (state == ST_IDLE) && ref_pending;
  assign ref_step  = (state == ST_R_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_ras_n <= 1'b1;
      mem_cas_n <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      wr_ack    <= 1'b0;
      col_q     <= '0;
      wr_q      <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      wr_ack   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ref_pending) begin
            state     <= ST_R_OPEN;
            mem_ras_n <= 1'b0;
            mem_addr  <= BUS_W'(ref_row);
          end else if (req_valid) begin
            state     <= ST_A_ROW;
            mem_ras_n <= 1'b0;
            mem_addr  <= BUS_W'(req_addr[ADDR_W-1:COL_BITS]);
            col_q     <= req_addr[COL_BITS-1:0];
            wr_q      <= req_write;
            if (req_write) mem_wdata <= req_wdata;
          end
        end
        ST_A_ROW: begin
          state     <= ST_A_COL;
          mem_addr  <= BUS_W'(col_q);
          mem_cas_n <= 1'b0;
          mem_we_n  <= !wr_q;
        end
        ST_A_COL: begin
          mem_cas_n <= 1'b1;
          mem_we_n  <= 1'b1;
          if (wr_q) begin
            state     <= ST_A_DONE;
            mem_ras_n <= 1'b1;
            wr_ack    <= 1'b1;
          end else begin
            state <= ST_A_CAPT;
          end
        end
        ST_A_CAPT: begin
          state     <= ST_A_PREP;
          mem_wdata <= mem_rdata;
          rd_data   <= mem_rdata;
        end
        ST_A_PREP: begin
          state     <= ST_A_REST;
          mem_cas_n <= 1'b0;
          mem_we_n  <= 1'b0;
        end
        ST_A_REST: begin
          state     <= ST_A_DONE;
          mem_cas_n <= 1'b1;
          mem_we_n  <= 1'b1;
          mem_ras_n <= 1'b1;
          rd_valid  <= 1'b1;
        end
        ST_A_DONE: state <= ST_IDLE;
        ST_R_OPEN: state <= ST_R_HOLD;
        ST_R_HOLD: begin
          state     <= ST_R_CLOSE;
          mem_ras_n <= 1'b1;
        end
        ST_R_CLOSE: begin
          if (ref_busy) begin
            state     <= ST_R_OPEN;
            mem_ras_n <= 1'b0;
            mem_addr  <= BUS_W'(ref_row);
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  cas_after_ras_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_cas_n |-> $past(!mem_ras_n));

  // R5
  we_only_with_cas_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_cas_n && $stable(mem_wdata)));

  // R6
  restore_before_done_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!mem_we_n && !mem_cas_n));

  // R2
  no_cas_in_sweep_chk: assert property (@(posedge clk) disable iff (rst)
    ref_busy |-> (mem_cas_n && mem_we_n));

  // R8
  single_done_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid || wr_ack) |-> ($onehot0({rd_valid, wr_ack}) && !req_ready));
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int ROW_BITS     = 11,
  parameter int COL_BITS     = 11,
  parameter int DATA_W       = 4,
  parameter int REF_INTERVAL = 15000,
  localparam int ADDR_W      = ROW_BITS + COL_BITS,
  localparam int BUS_W       = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_ack,
  output logic [BUS_W-1:0]  mem_addr,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic                ref_pending;
  logic                ref_busy;
  logic [ROW_BITS-1:0] ref_row;
  logic                ref_start;
  logic                ref_step;

  dram_refresh_seq #(
    .ROW_BITS(ROW_BITS),
    .INTERVAL(REF_INTERVAL)
  ) u_refresh (
    .clk    (clk),
    .rst    (rst),
    .start  (ref_start),
    .step   (ref_step),
    .pending(ref_pending),
    .busy   (ref_busy),
    .row    (ref_row)
  );

  dram_access_fsm #(
    .ROW_BITS(ROW_BITS),
    .COL_BITS(COL_BITS),
    .DATA_W  (DATA_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .wr_ack     (wr_ack),
    .mem_addr   (mem_addr),
    .mem_ras_n  (mem_ras_n),
    .mem_cas_n  (mem_cas_n),
    .mem_we_n   (mem_we_n),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .ref_pending(ref_pending),
    .ref_busy   (ref_busy),
    .ref_row    (ref_row),
    .ref_start  (ref_start),
    .ref_step   (ref_step)
  );
endmodule

// File: tb/dram_ctrl_test.sv
module dram_ctrl_test;
  localparam int IVL  = 300;
  localparam int NROW = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        rd_valid;
  logic [3:0]  rd_data;
  logic        wr_ack;
  logic [10:0] mem_addr;
  logic        mem_ras_n, mem_cas_n, mem_we_n;
  logic [3:0]  mem_wdata;
  logic [3:0]  mem_rdata = '0;

  dram_ctrl #(.REF_INTERVAL(IVL)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_ack(wr_ack),
    .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural memory and protocol monitor
  logic [3:0] mem   [int];
  logic [3:0] shadow[int];
  int  cur_row = 0, exp_ref_row = 0, sweeps = 0, gap_cnt = 0, clean_gaps = 0;
  bit  init_done = 0, saw_cas = 0, drained = 0, gap_on = 0, gap_clean = 0;
  int  drained_key = 0;
  logic [3:0] drained_val = '0;
  bit  prev_ras = 1, prev_rdv = 0;
  logic [3:0] prev_wdata = '0;
  bit  outstanding = 0;
  int  exp_row = 0, exp_col = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (gap_on) begin
        gap_cnt++;
        if (outstanding) gap_clean = 0;
      end
      if (!mem_ras_n && prev_ras) begin
        cur_row = int'(mem_addr);
        saw_cas = 0;
        if (gap_on) begin
          gap_on = 0;
          if (gap_clean) begin
            clean_gaps++;
            chk(gap_cnt == IVL + 1, "R7", "idle gap before next sweep", gap_cnt, IVL + 1);
          end
        end
      end
      if (!mem_cas_n) begin
        int key;
        key = (cur_row << 11) | int'(mem_addr);
        chk(!prev_ras, "R3", "row strobe low before column strobe", int'(prev_ras), 0);
        if (outstanding) begin
          chk(cur_row == exp_row, "R3", "row address", cur_row, exp_row);
          chk(int'(mem_addr) == exp_col, "R4", "column address", int'(mem_addr), exp_col);
        end
        saw_cas = 1;
        if (!mem_we_n) begin
          chk(mem_wdata == prev_wdata, "R5", "data set up before write strobe",
              int'(mem_wdata), int'(prev_wdata));
          if (drained && key == drained_key) begin
            chk(mem_wdata == drained_val, "R6", "restored value",
                int'(mem_wdata), int'(drained_val));
            drained = 0;
          end
          mem[key] = mem_wdata;
        end else begin
          mem_rdata   = mem.exists(key) ? mem[key] : 4'h0;
          drained     = 1;
          drained_key = key;
          drained_val = mem_rdata;
          mem[key]    = 4'h0;
        end
      end
      if (mem_ras_n && !prev_ras) begin
        if (!saw_cas) begin
          chk(cur_row == exp_ref_row, "R2", "refresh row order", cur_row, exp_ref_row);
          chk(!outstanding, "R9", "refresh during access", int'(outstanding), 0);
          exp_ref_row = (exp_ref_row + 1) % NROW;
          if (exp_ref_row == 0) begin
            sweeps++;
            init_done = 1;
            gap_on    = 1;
            gap_cnt   = 0;
            gap_clean = !outstanding;
          end
        end else begin
          chk(!drained, "R6", "row closed with drained cell", int'(drained), 0);
          drained = 0;
        end
      end
      if (req_ready) begin
        chk(init_done, "R1", "ready before first sweep", int'(init_done), 1);
        chk(exp_ref_row == 0, "R7", "ready during sweep", exp_ref_row, 0);
        chk(!outstanding, "R8", "ready while busy", int'(outstanding), 0);
      end
      if (rd_valid) chk(!prev_rdv, "R6", "rd_valid longer than one cycle", 1, 0);
      prev_ras   = mem_ras_n;
      prev_rdv   = rd_valid;
      prev_wdata = mem_wdata;
    end
  end

  task automatic host(input bit wr, input logic [21:0] a, input logic [3:0] d);
    int lat;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    chk(exp_ref_row == 0 && init_done, "R7", "accepted while refresh due or running",
        exp_ref_row, 0);
    outstanding = 1;
    exp_row = int'(a[21:11]);
    exp_col = int'(a[10:0]);
    lat = 0;
    @(negedge clk);
    req_valid = 0;
    while (!(rd_valid || wr_ack) && lat < 50) begin
      lat++;
      @(negedge clk);
    end
    lat++;
    if (wr) begin
      chk(wr_ack && lat == 3, "R5", "write ack latency", lat, 3);
      shadow[int'(a)] = d;
    end else begin
      logic [3:0] e;
      e = shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0;
      chk(rd_valid && lat == 6, "R6", "read latency", lat, 6);
      chk(rd_data == e, "R6", "read data", int'(rd_data), int'(e));
    end
    outstanding = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state (first cycle after reset: refresh not yet opened)
    chk(mem_cas_n && mem_we_n, "R1", "strobes after reset", int'({mem_cas_n, mem_we_n}), 3);
    chk(!req_ready && !rd_valid && !wr_ack, "R1", "handshake after reset",
        int'({req_ready, rd_valid, wr_ack}), 0);
    // directed corner addresses
    host(1, 22'h000000, 4'h5);
    host(1, 22'h3FFFFF, 4'hA);
    host(1, 22'h0007FF, 4'h3);
    host(1, 22'h3FF800, 4'hC);
    host(0, 22'h000000, 4'h0);
    host(0, 22'h000000, 4'h0);
    host(0, 22'h3FFFFF, 4'h0);
    host(0, 22'h0007FF, 4'h0);
    host(0, 22'h3FF800, 4'h0);
    host(0, 22'h3FF800, 4'h0);
    host(0, 22'h123456, 4'h0);
    // leave one full idle interval
    while (sweeps < 2) @(negedge clk);
    repeat (IVL + 40) @(negedge clk);
    // traffic across refresh phases
    s = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      logic [21:0] a;
      s = s * 32'd1103515245 + 32'd12345;
      a = {s[27:23], s[21:6]} ^ 22'(i);
      host(1, a, s[31:28]);
      host(0, a, 4'h0);
      if (i % 3 == 0) host(0, a, 4'h0);
    end
    while (exp_ref_row != 0) @(negedge clk);
    chk(sweeps >= 3, "R7", "periodic sweeps", sweeps, 3);
    chk(clean_gaps >= 1, "R7", "idle gaps measured", clean_gaps, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule